// File: doc/BRIEF.md
# ECC Error Status Logger

This block sits beside the error checker of a wide, ECC-protected memory read path and keeps a record of what went wrong. Each reported error arrives as one beat on a valid/ready input carrying a single/double indication, a bit-position field and the address of the access. The first error after a clear is captured in full: its address, its kind, and its position field. For a single error the position field is the index of the failing bit. For a double error it is the XOR of the two failing bit indices. Any error that arrives while one is already held leaves that capture untouched and only raises a sticky multiple-error flag.

Software reads the captured address and a 12-bit status word through a small register port. It discards the log by writing to a dedicated clear address. The same two values can be unloaded bit by bit through a serial debug shifter, without using the register port. An interrupt-style output stays high for as long as an error is logged.

The error input never applies back-pressure. `err_ready` is low only during reset. From the first clock after reset it stays high, and every cycle with `err_valid` high is one accepted error report.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, reads of the address register (index 0) and the status register (index 1) both return 0, and `irq` is low.
- R2: The first accepted error with `err_double` low sets status bit 1 and stores `err_pos` in status bits [11:5]. It also stores `err_addr` in the address register. Status bits 0, 2, 3 and 4 read 0.
- R3: The first accepted error with `err_double` high sets status bit 3 and stores `err_pos` (the XOR of the two failing bit indices) in bits [11:5]. It also stores `err_addr`. Status bits 0, 1, 2 and 4 read 0.
- R4: An error accepted while bit 1 or bit 3 is set raises status bit 0. The stored address, position field, bit 1 and bit 3 are kept unchanged. Bit 0 then stays set until a clear.
- R5: A write to register index 3 sets the whole status word and the address register to 0. A write to index 0, 1 or 2 changes nothing.
- R6: If a clear write and an accepted error fall in the same cycle, the error is logged as a first error (R2/R3) with bit 0 low.
- R7: `irq` is high exactly when status bit 1 or bit 3 is set. It rises in the cycle after the error beat.
- R8: A read presents `rd_data` together with `rd_valid` one cycle after `rd_en`. Index 0 returns the address, index 1 returns the status word zero-extended, and index 2 or 3 returns 0.
- R9: A `dbg_capture` pulse loads the address (`dbg_sel`=0) or the status word (`dbg_sel`=1) into the debug shifter. `dbg_sdo` then shows bit 0, and each `dbg_shift` pulse moves on to the next higher bit.
- R10: `err_ready` is high in every cycle after reset. Error beats in consecutive cycles are each accepted: the first is captured and the next sets bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Error report beat present |
| err_ready | output | 1 | Logger accepts reports (high out of reset) |
| err_double | input | 1 | 1 = uncorrectable double error, 0 = corrected single error |
| err_pos | input | 7 | Failing bit index, or XOR of the two indices |
| err_addr | input | 32 | Address of the failing access |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write index (3 = clear) |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read index |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| dbg_capture | input | 1 | Load the debug shifter |
| dbg_sel | input | 1 | Shifter source: 0 address, 1 status |
| dbg_shift | input | 1 | Advance the debug shifter one bit |
| dbg_sdo | output | 1 | Serial debug output, LSB first |
| irq | output | 1 | Error logged |

## Verification
Several properties are checked on every cycle:
- the multiple-error flag never drops except by a clear;
- the captured address and position never change while a capture is held;
- a clear alone empties the log, and a clear paired with an error leaves a fresh first capture;
- single and double flags are never set together;
- every accepted error leaves `irq` high.

Only the bench scenarios can show the values themselves. These are the exact packing of the status word over every position value, the XOR syndrome for many bit pairs, the read map including unmapped indices, the immunity to writes at other indices, and the bit order of the serial unload.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int STAT_W      = 12;
  localparam int POS_LSB     = 5;
  localparam int FLAG_MULTI  = 0;
  localparam int FLAG_SINGLE = 1;
  localparam int FLAG_DOUBLE = 3;
  localparam int REG_AW      = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_ADDR  = 2'd0,
    REG_STAT  = 2'd1,
    REG_SPARE = 2'd2,
    REG_CLEAR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int ADDR_W = 32,
  parameter int POS_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              dbl,
  input  logic [POS_W-1:0]  pos,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [POS_W-1:0]  cap_pos,
  output logic              f_single,
  output logic              f_double,
  output logic              f_multi
);
  logic logged;
  assign logged = f_single | f_double;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_pos  <= '0;
      f_single <= 1'b0;
      f_double <= 1'b0;
      f_multi  <= 1'b0;
    end else if (fire && (!logged || clr)) begin
      cap_addr <= addr;
      cap_pos  <= pos;
      f_single <= !dbl;
      f_double <= dbl;
      f_multi  <= 1'b0;
    end else if (fire) begin
      f_multi  <= 1'b1;
    end else if (clr) begin
      cap_addr <= '0;
      cap_pos  <= '0;
      f_single <= 1'b0;
      f_double <= 1'b0;
      f_multi  <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_log_regif.sv
module ecc_log_regif
  import ecc_log_pkg::*;
#(
  parameter int RD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [RD_W-1:0]   addr_word,
  input  logic [RD_W-1:0]   stat_word,
  output logic              rd_valid,
  output logic [RD_W-1:0]   rd_data,
  output logic              clr
);
  assign clr = wr_en && (reg_sel_e'(wr_addr) == REG_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (reg_sel_e'(rd_addr))
          REG_ADDR: rd_data <= addr_word;
          REG_STAT: rd_data <= stat_word;
          default:  rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ecc_log_serial.sv
module ecc_log_serial #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         sel,
  input  logic         shift,
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  output logic         sdo
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)       sh <= '0;
    else if (capture) sh <= sel ? word_b : word_a;
    else if (shift)   sh <= {1'b0, sh[W-1:1]};
  end

  assign sdo = sh[0];
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      err_valid,
  output logic                      err_ready,
  input  logic                      err_double,
  input  logic [STAT_W-POS_LSB-1:0] err_pos,
  input  logic [ADDR_W-1:0]         err_addr,
  input  logic                      wr_en,
  input  logic [REG_AW-1:0]         wr_addr,
  input  logic                      rd_en,
  input  logic [REG_AW-1:0]         rd_addr,
  output logic                      rd_valid,
  output logic [((ADDR_W > STAT_W) ? ADDR_W : STAT_W)-1:0] rd_data,
  input  logic                      dbg_capture,
  input  logic                      dbg_sel,
  input  logic                      dbg_shift,
  output logic                      dbg_sdo,
  output logic                      irq
);
  localparam int POS_W = STAT_W - POS_LSB;
  localparam int RD_W  = (ADDR_W > STAT_W) ? ADDR_W : STAT_W;

  logic              err_fire, clr;
  logic [ADDR_W-1:0] cap_addr;
  logic [POS_W-1:0]  cap_pos;
  logic              f_single, f_double, f_multi;
  logic [STAT_W-1:0] stat;
  logic [RD_W-1:0]   addr_word, stat_word;

  always_ff @(posedge clk) begin
    if (!rst_n) err_ready <= 1'b0;
    else        err_ready <= 1'b1;
  end

  assign err_fire = err_valid && err_ready;

  ecc_log_capture #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .fire(err_fire), .dbl(err_double),
    .pos(err_pos), .addr(err_addr), .clr(clr),
    .cap_addr(cap_addr), .cap_pos(cap_pos),
    .f_single(f_single), .f_double(f_double), .f_multi(f_multi)
  );

  always_comb begin
    stat                       = '0;
    stat[FLAG_MULTI]           = f_multi;
    stat[FLAG_SINGLE]          = f_single;
    stat[FLAG_DOUBLE]          = f_double;
    stat[STAT_W-1:POS_LSB]     = cap_pos;
  end

  assign addr_word = RD_W'(cap_addr);
  assign stat_word = RD_W'(stat);
  assign irq       = f_single | f_double;

  ecc_log_regif #(.RD_W(RD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .addr_word(addr_word),
    .stat_word(stat_word), .rd_valid(rd_valid), .rd_data(rd_data), .clr(clr)
  );

  ecc_log_serial #(.W(RD_W)) u_dbg (
    .clk(clk), .rst_n(rst_n), .capture(dbg_capture), .sel(dbg_sel),
    .shift(dbg_shift), .word_a(addr_word), .word_b(stat_word), .sdo(dbg_sdo)
  );
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk #(
  parameter int ADDR_W = 32,
  parameter int POS_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_fire,
  input logic              clr,
  input logic              irq,
  input logic              f_single,
  input logic              f_double,
  input logic              f_multi,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [POS_W-1:0]  cap_pos
);
  // R4
  multi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_multi && !clr) |=> f_multi);

  // R4
  capture_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((f_single || f_double) && !clr) |=> ($stable(cap_addr) && $stable(cap_pos)));

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !err_fire) |=> (!f_single && !f_double && !f_multi));

  // R6
  clear_with_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && err_fire) |=> (!f_multi && (f_single || f_double)));

  // R2
  kind_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_single && f_double));

  // R7
  irq_after_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_fire |=> irq);
endmodule

bind ecc_err_logger ecc_err_logger_chk #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_fire(err_fire), .clr(clr), .irq(irq),
  .f_single(f_single), .f_double(f_double), .f_multi(f_multi),
  .cap_addr(cap_addr), .cap_pos(cap_pos)
);

// File: tb/ecc_err_logger_tb.sv
module ecc_err_logger_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0, err_double = 1'b0;
  logic        err_ready;
  logic [6:0]  err_pos = '0;
  logic [31:0] err_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        dbg_capture = 1'b0, dbg_sel = 1'b0, dbg_shift = 1'b0;
  logic        dbg_sdo, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ecc_err_logger u_dut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ready(err_ready),
    .err_double(err_double), .err_pos(err_pos), .err_addr(err_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .dbg_capture(dbg_capture),
    .dbg_sel(dbg_sel), .dbg_shift(dbg_shift), .dbg_sdo(dbg_sdo), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] stat_of(bit s, bit d, bit m, int p);
    return (32'(p) << 5) | (32'(d) << 3) | (32'(s) << 1) | 32'(m);
  endfunction

  task automatic send_err(input bit d, input int p, input logic [31:0] a);
    err_valid = 1'b1; err_double = d; err_pos = 7'(p); err_addr = a;
    tick();
    err_valid = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] idx);
    wr_en = 1'b1; wr_addr = idx;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] idx, output logic [31:0] d, input string req);
    rd_en = 1'b1; rd_addr = idx;
    tick();
    rd_en = 1'b0;
    check(rd_valid === 1'b1, req, 32'(rd_valid), 32'd1);
    d = rd_data;
  endtask

  task automatic serial_read(input bit sel, output logic [31:0] w);
    dbg_capture = 1'b1; dbg_sel = sel;
    tick();
    dbg_capture = 1'b0;
    for (int i = 0; i < 32; i++) begin
      w[i] = dbg_sdo;
      dbg_shift = 1'b1;
      tick();
      dbg_shift = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1, R10: reset state
    read_reg(2'd0, d, "R1"); check(d == 0, "R1", d, 0);
    read_reg(2'd1, d, "R1"); check(d == 0, "R1", d, 0);
    check(irq == 1'b0, "R1", 32'(irq), 0);
    check(err_ready == 1'b1, "R10", 32'(err_ready), 1);

    // R2, R4, R7: sweep of every single-error position
    for (int p = 0; p < 128; p++) begin
      do_write(2'd3);
      a = 32'h1000_0000 + 32'(p) * 32'h0001_0004;
      send_err(1'b0, p, a);
      check(irq == 1'b1, "R7", 32'(irq), 1);
      read_reg(2'd1, d, "R2"); check(d == stat_of(1, 0, 0, p), "R2", d, stat_of(1, 0, 0, p));
      read_reg(2'd0, d, "R2"); check(d == a, "R2", d, a);
      send_err(1'b1, (p + 17) % 128, ~a);
      read_reg(2'd1, d, "R4"); check(d == stat_of(1, 0, 1, p), "R4", d, stat_of(1, 0, 1, p));
      read_reg(2'd0, d, "R4"); check(d == a, "R4", d, a);
    end

    // R3: double errors with XOR syndromes over bit pairs of a 72-bit word
    for (int x = 0; x < 72; x++) begin
      int y = (x * 5 + 3) % 72;
      if (y == x) continue;
      do_write(2'd3);
      a = 32'hC000_0000 | 32'(x << 8) | 32'(y);
      send_err(1'b1, x ^ y, a);
      read_reg(2'd1, d, "R3"); check(d == stat_of(0, 1, 0, x ^ y), "R3", d, stat_of(0, 1, 0, x ^ y));
      read_reg(2'd0, d, "R3"); check(d == a, "R3", d, a);
      check(irq == 1'b1, "R7", 32'(irq), 1);
    end

    // R5: writes to other indices have no effect, clear empties the log
    do_write(2'd3);
    send_err(1'b0, 42, 32'hDEAD_BEE0);
    for (int k = 0; k < 3; k++) begin
      do_write(2'(k));
      read_reg(2'd1, d, "R5"); check(d == stat_of(1, 0, 0, 42), "R5", d, stat_of(1, 0, 0, 42));
      read_reg(2'd0, d, "R5"); check(d == 32'hDEAD_BEE0, "R5", d, 32'hDEAD_BEE0);
    end
    do_write(2'd3);
    read_reg(2'd1, d, "R5"); check(d == 0, "R5", d, 0);
    read_reg(2'd0, d, "R5"); check(d == 0, "R5", d, 0);
    check(irq == 1'b0, "R7", 32'(irq), 0);

    // R6: clear and error in the same cycle
    send_err(1'b0, 9, 32'h1111_2222);
    send_err(1'b0, 11, 32'h3333_4444);
    wr_en = 1'b1; wr_addr = 2'd3;
    send_err(1'b1, 20, 32'h5555_6666);
    wr_en = 1'b0;
    read_reg(2'd1, d, "R6"); check(d == stat_of(0, 1, 0, 20), "R6", d, stat_of(0, 1, 0, 20));
    read_reg(2'd0, d, "R6"); check(d == 32'h5555_6666, "R6", d, 32'h5555_6666);

    // R10: back-to-back beats
    do_write(2'd3);
    err_valid = 1'b1; err_double = 1'b0; err_pos = 7'd5; err_addr = 32'hAAAA_0001;
    tick();
    check(err_ready == 1'b1, "R10", 32'(err_ready), 1);
    err_double = 1'b1; err_pos = 7'd6; err_addr = 32'hBBBB_0002;
    tick();
    err_valid = 1'b0;
    read_reg(2'd1, d, "R10"); check(d == stat_of(1, 0, 1, 5), "R10", d, stat_of(1, 0, 1, 5));
    read_reg(2'd0, d, "R10"); check(d == 32'hAAAA_0001, "R10", d, 32'hAAAA_0001);

    // R8: unmapped indices read 0
    read_reg(2'd2, d, "R8"); check(d == 0, "R8", d, 0);
    read_reg(2'd3, d, "R8"); check(d == 0, "R8", d, 0);

    // R9: serial unload of both registers
    serial_read(1'b0, d); check(d == 32'hAAAA_0001, "R9", d, 32'hAAAA_0001);
    serial_read(1'b1, d); check(d == stat_of(1, 0, 1, 5), "R9", d, stat_of(1, 0, 1, 5));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule